// File: doc/BRIEF.md
# Horizontal Clock Phase Generator

This block builds the horizontal-rate clock family for an area image sensor from one fast synchronous clock. The fast clock runs at twice the master pixel reference rate, so one master period spans two fast cycles, every half-rate output spans four and the colour carrier spans eight. A free-running three-bit phase count drives all outputs. Each output is a registered decode of that count, so every edge lands on a fast-clock edge with no combinational glitches.

The outputs are:
- a half-rate delay-line clock;
- an oscillator output that is the inverse of the master clock;
- two complementary transfer clocks;
- four half-rate copies of those clocks, two in phase and two lagging by a quarter period (90 degrees);
- a quarter-rate colour carrier, which rises with transfer clock 1 or with transfer clock 2, as chosen by a select input.

A line-rate toggle flips on every rising edge of the horizontal reference. The vertical reference clears it. When inversion is enabled, the toggle inverts the carrier. Two sampling pulses follow transfer clock 1: the first appears only while the carrier is high, and the second only while it is low.

Top module: `hclk_phase_gen`

## Requirements
- R1: While `rst_n` is low, every output is 0. After release, the phase count restarts at 0. The first rising clock edge then loads the outputs for phase 0, where the transfer clock 1 output `h1_o` is 1.
- R2: `dl_clk_o` has a period of 4 cycles. After the edge that loads phase p, it is high for p mod 4 in {0,1}.
- R3: `osc_o` is the inverse of the master clock. The master clock is high on even phases, so `osc_o` is high exactly on odd phases and toggles on every cycle.
- R4: `h1_o` is high for p mod 4 in {0,1}. `h2_o` is always its complement.
- R5: `ck1_o` equals `h1_o` and `ck3_o` equals `h2_o` on every cycle.
- R6: `ck2_o` and `ck4_o` repeat `ck1_o` and `ck3_o` one cycle later. This is a quarter-period (90 degree) lag.
- R7: With `car_sel`=0 and no inversion, `car_o` has a period of 8 cycles. It is high for phases 0 to 3, so it rises together with `h1_o`.
- R8: With `car_sel`=1 and no inversion, `car_o` is high for phases 2 to 5, so it rises together with `h2_o`.
- R9: Each rising edge of `hd_ref` flips an internal line toggle. While `car_inv_en`=1 and the toggle is set, `car_o` is inverted. While `car_inv_en`=0, the toggle has no effect on `car_o`.
- R10: `vd_ref` high clears the line toggle on the next edge, and it wins over a simultaneous `hd_ref` rising edge.
- R11: `sp1_o` is `h1_o` gated by `car_o` high. `sp2_o` is `h1_o` gated by `car_o` low. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the master reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_ref | input | 1 | Horizontal reference; rising edge flips the line toggle |
| vd_ref | input | 1 | Vertical reference; clears the line toggle |
| car_sel | input | 1 | Carrier phase: 0 aligns to transfer clock 1, 1 to transfer clock 2 |
| car_inv_en | input | 1 | Enables line-rate carrier inversion |
| dl_clk_o | output | 1 | Half-rate delay-line clock |
| osc_o | output | 1 | Inverse of master clock |
| h1_o | output | 1 | Transfer clock 1 |
| h2_o | output | 1 | Transfer clock 2 |
| ck1_o | output | 1 | Half-rate clock in phase with transfer clock 1 |
| ck2_o | output | 1 | Half-rate clock lagging transfer clock 1 by 90 degrees |
| ck3_o | output | 1 | Half-rate clock in phase with transfer clock 2 |
| ck4_o | output | 1 | Half-rate clock lagging transfer clock 2 by 90 degrees |
| car_o | output | 1 | Quarter-rate colour carrier |
| sp1_o | output | 1 | Sampling pulse while carrier high |
| sp2_o | output | 1 | Sampling pulse while carrier low |

## Verification
The carrier is driven with both select values, with inversion off and on, so that a swapped phase offset or an ignored enable shows up as a wrong level within one carrier period. Horizontal reference pulses arrive while inversion is off, which shows the hidden toggle has no visible effect. The later pulses with inversion on show that the toggle was counting all along. A vertical pulse issued together with a horizontal edge separates clear priority from toggling. A mid-run reset shows the phase restart and the all-zero reset state.

// File: rtl/hcg_pkg.sv
package hcg_pkg;
  localparam int PH_W   = 3;
  localparam int CAR_SH = 2;  // carrier offset in fast cycles for select=1

  typedef logic [PH_W-1:0] phase_t;

  typedef struct packed {
    logic dl;
    logic osc;
    logic h1;
    logic h2;
    logic ck1;
    logic ck2;
    logic ck3;
    logic ck4;
    logic car;
    logic sp1;
    logic sp2;
  } hout_t;

  // transfer clock 1 level for a phase: high on the first half of each 4-cycle period
  function automatic logic xfer1_lvl(phase_t p);
    return ~p[1];
  endfunction

  // master clock level: high on even phases
  function automatic logic mclk_lvl(phase_t p);
    return ~p[0];
  endfunction

  // carrier before inversion: high for the four phases following the chosen rising edge
  function automatic logic car_base(phase_t p, logic sel);
    phase_t q;
    q = sel ? p - phase_t'(CAR_SH) : p;
    return ~q[PH_W-1];
  endfunction
endpackage

// File: rtl/hcg_phase_ctr.sv
module hcg_phase_ctr
  import hcg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t ph
);
  phase_t ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_q + phase_t'(1);
  end

  assign ph = ph_q;
endmodule

// File: rtl/hcg_line_inv.sv
module hcg_line_inv (
  input  logic clk,
  input  logic rst_n,
  input  logic hd_ref,
  input  logic vd_ref,
  output logic hd_rise,
  output logic inv_state
);
  logic hd_q;
  logic inv_q;

  assign hd_rise = hd_ref & ~hd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      hd_q <= hd_ref;
      if (vd_ref)       inv_q <= 1'b0;
      else if (hd_rise) inv_q <= ~inv_q;
    end
  end

  assign inv_state = inv_q;
endmodule

// File: rtl/hcg_pulse_fmt.sv
module hcg_pulse_fmt
  import hcg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t ph,
  input  logic   car_sel,
  input  logic   car_flip,
  output hout_t  hout
);
  phase_t ph_lag;
  logic   x1_now;
  logic   x1_lag;
  logic   car_now;
  hout_t  nxt;
  hout_t  hout_q;

  assign ph_lag  = ph - phase_t'(1);
  assign x1_now  = xfer1_lvl(ph);
  assign x1_lag  = xfer1_lvl(ph_lag);
  assign car_now = car_base(ph, car_sel) ^ car_flip;

  always_comb begin
    nxt.dl  = x1_now;
    nxt.osc = ~mclk_lvl(ph);
    nxt.h1  = x1_now;
    nxt.h2  = ~x1_now;
    nxt.ck1 = x1_now;
    nxt.ck2 = x1_lag;
    nxt.ck3 = ~x1_now;
    nxt.ck4 = ~x1_lag;
    nxt.car = car_now;
    nxt.sp1 = x1_now & car_now;
    nxt.sp2 = x1_now & ~car_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hout_q <= '0;
    else        hout_q <= nxt;
  end

  assign hout = hout_q;
endmodule

// File: rtl/hclk_phase_gen.sv
module hclk_phase_gen
  import hcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hd_ref,
  input  logic vd_ref,
  input  logic car_sel,
  input  logic car_inv_en,
  output logic dl_clk_o,
  output logic osc_o,
  output logic h1_o,
  output logic h2_o,
  output logic ck1_o,
  output logic ck2_o,
  output logic ck3_o,
  output logic ck4_o,
  output logic car_o,
  output logic sp1_o,
  output logic sp2_o
);
  phase_t ph;
  logic   hd_rise;
  logic   inv_state;
  logic   car_flip;
  hout_t  hout;

  hcg_phase_ctr u_ctr (.clk(clk), .rst_n(rst_n), .ph(ph));

  hcg_line_inv u_inv (
    .clk(clk), .rst_n(rst_n), .hd_ref(hd_ref), .vd_ref(vd_ref),
    .hd_rise(hd_rise), .inv_state(inv_state)
  );

  assign car_flip = car_inv_en & inv_state;

  hcg_pulse_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .ph(ph), .car_sel(car_sel),
    .car_flip(car_flip), .hout(hout)
  );

  assign dl_clk_o = hout.dl;
  assign osc_o    = hout.osc;
  assign h1_o     = hout.h1;
  assign h2_o     = hout.h2;
  assign ck1_o    = hout.ck1;
  assign ck2_o    = hout.ck2;
  assign ck3_o    = hout.ck3;
  assign ck4_o    = hout.ck4;
  assign car_o    = hout.car;
  assign sp1_o    = hout.sp1;
  assign sp2_o    = hout.sp2;
endmodule

// File: rtl/hclk_phase_gen_chk.sv
module hclk_phase_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic vd_ref,
  input logic hd_rise,
  input logic inv_state,
  input logic osc_o,
  input logic h1_o,
  input logic h2_o,
  input logic ck1_o,
  input logic ck2_o,
  input logic ck3_o,
  input logic ck4_o,
  input logic sp1_o,
  input logic sp2_o
);
  logic [1:0] seen;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen <= '0;
    else if (seen != 2'd2) seen <= seen + 2'd1;
  end
  assign warm = (seen == 2'd2);

  // R3
  osc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (osc_o != $past(osc_o)));

  // R4
  xfer_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (h1_o != h2_o));

  // R6
  quad_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> ((ck2_o == $past(ck1_o)) && (ck4_o == $past(ck3_o))));

  // R10
  vd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(vd_ref)) |-> !inv_state);

  // R9
  hd_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(hd_rise) && !$past(vd_ref)) |-> (inv_state != $past(inv_state)));

  // R11
  sp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sp1_o && sp2_o));
endmodule

bind hclk_phase_gen hclk_phase_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vd_ref(vd_ref), .hd_rise(hd_rise),
  .inv_state(inv_state), .osc_o(osc_o), .h1_o(h1_o), .h2_o(h2_o),
  .ck1_o(ck1_o), .ck2_o(ck2_o), .ck3_o(ck3_o), .ck4_o(ck4_o),
  .sp1_o(sp1_o), .sp2_o(sp2_o)
);

// File: tb/hclk_phase_gen_test.sv
module hclk_phase_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hd_ref = 1'b0, vd_ref = 1'b0, car_sel = 1'b0, car_inv_en = 1'b0;
  logic dl_clk_o, osc_o, h1_o, h2_o, ck1_o, ck2_o, ck3_o, ck4_o, car_o, sp1_o, sp2_o;

  always #2 clk = ~clk;  // 250 MHz

  hclk_phase_gen uut (
    .clk(clk), .rst_n(rst_n), .hd_ref(hd_ref), .vd_ref(vd_ref),
    .car_sel(car_sel), .car_inv_en(car_inv_en),
    .dl_clk_o(dl_clk_o), .osc_o(osc_o), .h1_o(h1_o), .h2_o(h2_o),
    .ck1_o(ck1_o), .ck2_o(ck2_o), .ck3_o(ck3_o), .ck4_o(ck4_o),
    .car_o(car_o), .sp1_o(sp1_o), .sp2_o(sp2_o)
  );

  typedef struct {
    logic [10:0] v;
    string       car_tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  int m_ph = 0;
  bit m_hdp = 0;
  bit m_inv = 0;
  int m_clr_age = 99;

  // driver: predicts each output word from the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_hdp = 0; m_inv = 0; m_clr_age = 99;
    end else begin
      exp_t e;
      bit h1e, q1, base, car, osc;
      int pl;
      h1e  = (m_ph % 4) < 2;                               // R4
      pl   = (m_ph + 7) % 8;
      q1   = (pl % 4) < 2;                                 // R6
      osc  = (m_ph % 2) == 1;                              // R3
      base = car_sel ? (m_ph >= 2 && m_ph <= 5) : (m_ph < 4); // R7 R8
      car  = base ^ (car_inv_en & m_inv);                  // R9
      e.v  = {h1e, osc, h1e, !h1e, h1e, q1, !h1e, !q1, car, car & h1e, !car & h1e};
      if (m_clr_age < 8)          e.car_tag = "R10";
      else if (car_inv_en && m_inv) e.car_tag = "R9";
      else if (car_sel)           e.car_tag = "R8";
      else                        e.car_tag = "R7";
      exp_q.push_back(e);
      if (vd_ref) begin
        if (m_inv) m_clr_age = 0;
        m_inv = 0;
      end else if (hd_ref && !m_hdp) m_inv = !m_inv;
      m_hdp = hd_ref;
      m_ph = (m_ph + 1) % 8;
      if (m_clr_age < 99) m_clr_age++;
    end
  end

  function automatic string bit_tag(int i, string ct);
    case (i)
      10: return "R2";
      9:  return "R3";
      8, 7: return "R4";
      6, 4: return "R5";
      5, 3: return "R6";
      2:  return ct;
      default: return "R11";
    endcase
  endfunction

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    logic [10:0] act;
    act = {dl_clk_o, osc_o, h1_o, h2_o, ck1_o, ck2_o, ck3_o, ck4_o, car_o, sp1_o, sp2_o};
    if (!done) begin
      if (!rst_n) begin
        checks++;
        if (act !== '0) begin
          fails++;
          $display("FAIL R1 reset outputs act=%b exp=%b", act, 11'b0);
        end
      end else if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        for (int i = 0; i < 11; i++) begin
          checks++;
          if (act[i] !== e.v[i]) begin
            fails++;
            $display("FAIL %s bit%0d act=%b exp=%b at %0t", bit_tag(i, e.car_tag), i, act[i], e.v[i], $time);
          end
        end
      end
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic hd_pulse();
    @(negedge clk); hd_ref = 1'b1;
    idle(3);
    hd_ref = 1'b0;
  endtask

  task automatic do_reset(int n);
    @(negedge clk); #1 rst_n = 1'b0;
    idle(n);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    idle(4);
    #1 rst_n = 1'b1;
    // first loaded word is phase 0: h1 high (R1)
    @(negedge clk);
    checks++;
    if (h1_o !== 1'b1) begin
      fails++;
      $display("FAIL R1 first phase h1 act=%b exp=1", h1_o);
    end
    idle(30);                 // R7 carrier aligned to h1
    hd_pulse(); idle(20);     // R9 toggle hidden while disabled
    car_sel = 1'b1; idle(30); // R8
    car_inv_en = 1'b1; idle(20);  // toggle now visible (R9)
    hd_pulse(); idle(20);
    car_sel = 1'b0; idle(20);
    hd_pulse(); idle(20);
    @(negedge clk); vd_ref = 1'b1; hd_ref = 1'b1;  // R10 clear beats edge
    @(negedge clk); vd_ref = 1'b0;
    idle(3); hd_ref = 1'b0;
    idle(20);
    hd_pulse(); idle(10);
    @(negedge clk); vd_ref = 1'b1;  // R10 plain clear
    @(negedge clk); vd_ref = 1'b0;
    idle(20);
    do_reset(3);              // R1 restart mid-run
    @(negedge clk);
    checks++;
    if (h1_o !== 1'b1) begin
      fails++;
      $display("FAIL R1 restart h1 act=%b exp=1", h1_o);
    end
    idle(30);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule